// File: doc/BRIEF.md
# Page-Mode Flash Read Controller

This block sits on the host side of a parallel NOR-type flash that offers an asynchronous four-word page read. A client hands it one word address at a time over a valid/ready request port. The controller then drives the chip-select, output-strobe and write-strobe lines and the address bus, waits a programmed number of clock cycles, and samples the 16-bit data bus. The word comes back on a response port as a single-cycle valid pulse. Only one request is outstanding at any time.

The controller remembers which page is open. A read that lands in the open page while chip select has stayed asserted pays only the short in-page delay. Any other read pays the full delay. This covers the first read after chip select falls, and a read to a different page. Chip select is released after a programmable number of idle cycles with no request, and this closes the page.

The finite-state machine has four states. CLOSED: chip select released, no open page. OPEN: chip select held and the page open, waiting for a request while the idle timer runs. ACCESS: both strobes low, counting down the access delay. CAPTURE: one more cycle with the strobes low, after which the data bus is latched. The transitions are as follows. CLOSED goes to ACCESS when a request is accepted. OPEN goes to ACCESS on an accepted request, or to CLOSED on idle timeout. ACCESS goes to CAPTURE when the delay expires. CAPTURE always goes to OPEN and raises the response.

Top module: `pfr_read_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, chip select, output strobe and write strobe are high, rsp_valid is 0 and req_ready is 1.
- R2: The write strobe is always high. Chip select and the output strobe are low from the cycle after a request is accepted until its response. The output strobe is never low while chip select is high.
- R3: The full word address is on the address bus from the cycle after acceptance and stays unchanged until the response. Address bits [ADDR_W-1:2] name the page and bits [1:0] name the word within it.
- R4: A request accepted while chip select is released is a miss. rsp_valid rises W_MISS+1 cycles after the accepting clock edge, where W_MISS = max(T_ACC, T_CE, T_OE).
- R5: A request to the open page, accepted while chip select has stayed low since the previous access, is a hit. rsp_valid rises W_HIT+1 cycles after the accepting edge, where W_HIT = max(T_PACC, T_OE).
- R6: A request to a different page while a page is open pays the miss latency W_MISS+1, and that page then becomes the open page.
- R7: Count the response cycle as cycle 0. If no request is presented in cycles 0 to IDLE_TO-1, chip select goes high from cycle IDLE_TO on. A request to the same page after that is a miss.
- R8: rsp_data holds the data-bus value sampled on the edge that raises rsp_valid. rsp_valid is high for exactly one cycle per accepted request.
- R9: req_ready is low from the cycle after acceptance until the response cycle, and is high again in the response cycle.
- R10: While a page is open between accesses, including the response cycle, the output strobe is high. Each access therefore starts with a new falling edge of the output strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W | Word address of the request |
| rsp_valid | output | 1 | One-cycle pulse: rsp_data is valid |
| rsp_data | output | DATA_W | Word read from the flash |
| fl_ce_n | output | 1 | Flash chip select, active low |
| fl_oe_n | output | 1 | Flash output strobe, active low |
| fl_we_n | output | 1 | Flash write strobe, active low (held high) |
| fl_addr | output | ADDR_W | Flash word address bus |
| fl_dq | input | DATA_W | Flash data bus |

## Verification
The flash is modelled in the bench by counters for address age, output-strobe age and page-load state. The model returns the inverted word until each delay has passed, so any read taken too early shows up as wrong data, and latency is also counted cycle by cycle.

Directed sequences cover several cases:
- a cold miss;
- consecutive hits on all four word offsets;
- a page change while the page is open;
- idle gaps of exactly IDLE_TO-1 and IDLE_TO cycles, which separate a retained page from a released one.

Seeded random reads mix same-page, next-page and far addresses with short and near-timeout gaps. They check that hit and miss classification stays correct when the two kinds interleave.

// File: rtl/pfr_pkg.sv
package pfr_pkg;

    typedef enum logic [1:0] {
        ST_CLOSED  = 2'd0,
        ST_OPEN    = 2'd1,
        ST_ACCESS  = 2'd2,
        ST_CAPTURE = 2'd3
    } pfr_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        return max2(max2(a, b), c);
    endfunction

endpackage

// File: rtl/pfr_page_track.sv
module pfr_page_track #(
    parameter int PAGE_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              clear,
    input  logic [PAGE_W-1:0] page_in,
    output logic              hit
);

    logic              valid_q;
    logic [PAGE_W-1:0] page_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            page_q  <= '0;
        end else if (clear) begin
            valid_q <= 1'b0;
        end else if (load) begin
            valid_q <= 1'b1;
            page_q  <= page_in;
        end
    end

    assign hit = valid_q && (page_q == page_in);

endmodule

// File: rtl/pfr_delay_timer.sv
module pfr_delay_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/pfr_read_ctrl.sv
module pfr_read_ctrl #(
    parameter int ADDR_W  = 22,
    parameter int DATA_W  = 16,
    parameter int T_ACC   = 6,
    parameter int T_CE    = 5,
    parameter int T_PACC  = 2,
    parameter int T_OE    = 3,
    parameter int IDLE_TO = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              fl_ce_n,
    output logic              fl_oe_n,
    output logic              fl_we_n,
    output logic [ADDR_W-1:0] fl_addr,
    input  logic [DATA_W-1:0] fl_dq
);

    import pfr_pkg::*;

    localparam int W_MISS = max3(T_ACC, T_CE, T_OE);
    localparam int W_HIT  = max2(T_PACC, T_OE);
    localparam int T_MAX  = max2(W_MISS, IDLE_TO);
    localparam int CNT_W  = $clog2(T_MAX + 1);
    localparam int PAGE_W = ADDR_W - 2;

    pfr_state_e state_q, state_d;

    logic             accept;
    logic             page_hit;
    logic             timeout;
    logic             tmr_load;
    logic             tmr_dec;
    logic             tmr_zero;
    logic [CNT_W-1:0] tmr_val;

    assign accept  = req_valid && req_ready;
    assign timeout = (state_q == ST_OPEN) && !req_valid && tmr_zero;

    pfr_page_track #(
        .PAGE_W (PAGE_W)
    ) page_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .clear   (timeout),
        .page_in (req_addr[ADDR_W-1:2]),
        .hit     (page_hit)
    );

    pfr_delay_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .dec      (tmr_dec),
        .zero     (tmr_zero)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CLOSED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and timer control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        tmr_dec  = 1'b0;
        unique case (state_q)
            ST_CLOSED: begin
                if (accept) begin
                    state_d  = ST_ACCESS;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(W_MISS - 1);
                end
            end
            ST_OPEN: begin
                if (accept) begin
                    state_d  = ST_ACCESS;
                    tmr_load = 1'b1;
                    tmr_val  = page_hit ? CNT_W'(W_HIT - 1) : CNT_W'(W_MISS - 1);
                end else if (tmr_zero) begin
                    state_d = ST_CLOSED;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_ACCESS: begin
                if (tmr_zero) begin
                    state_d = ST_CAPTURE;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_CAPTURE: begin
                state_d  = ST_OPEN;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(IDLE_TO - 1);
            end
        endcase
    end

    // Strobe and handshake outputs
    always_comb begin
        fl_we_n   = 1'b1;
        fl_ce_n   = (state_q == ST_CLOSED);
        fl_oe_n   = !((state_q == ST_ACCESS) || (state_q == ST_CAPTURE));
        req_ready = (state_q == ST_CLOSED) || (state_q == ST_OPEN);
    end

    // Address launch and data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_addr   <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            if (accept) begin
                fl_addr <= req_addr;
            end
            rsp_valid <= (state_q == ST_CAPTURE);
            if (state_q == ST_CAPTURE) begin
                rsp_data <= fl_dq;
            end
        end
    end

endmodule

// File: rtl/pfr_read_ctrl_chk.sv
module pfr_read_ctrl_chk #(
    parameter int ADDR_W = 22,
    parameter int W_HIT  = 3,
    parameter int W_MISS = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              fl_ce_n,
    input logic              fl_oe_n,
    input logic [ADDR_W-1:0] fl_addr
);

    localparam int LAT_W = $clog2(W_MISS + 4) + 1;
    localparam logic [LAT_W-1:0] LAT_MAX = '1;

    logic [LAT_W-1:0] lat_q;
    logic             fresh_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q   <= '0;
            fresh_q <= 1'b0;
        end else if (req_valid && req_ready) begin
            lat_q   <= '0;
            fresh_q <= fl_ce_n;
        end else if (lat_q != LAT_MAX) begin
            lat_q <= lat_q + 1'b1;
        end
    end

    assert_oe_needs_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> !fl_ce_n);

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(fl_addr));

    assert_miss_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && fresh_q) |-> (lat_q == LAT_W'(W_MISS + 1)));

    assert_latency_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((lat_q == LAT_W'(W_HIT + 1)) || (lat_q == LAT_W'(W_MISS + 1))));

    assert_ce_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_ce_n) |-> ($past(req_ready) && $past(fl_oe_n)));

    assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_oe_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> fl_oe_n);

endmodule

bind pfr_read_ctrl pfr_read_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .W_HIT  (W_HIT),
    .W_MISS (W_MISS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .fl_ce_n   (fl_ce_n),
    .fl_oe_n   (fl_oe_n),
    .fl_addr   (fl_addr)
);

// File: tb/pfr_read_ctrl_tb.sv
module pfr_read_ctrl_tb_top;

    localparam int AW      = 22;
    localparam int DW      = 16;
    localparam int T_ACC   = 6;
    localparam int T_CE    = 5;
    localparam int T_PACC  = 2;
    localparam int T_OE    = 3;
    localparam int IDLE_TO = 8;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int T_FULL = imax(T_ACC, T_CE);
    localparam int E_MISS = imax(T_FULL, T_OE);
    localparam int E_HIT  = imax(T_PACC, T_OE);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          fl_ce_n, fl_oe_n, fl_we_n;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_dq = '0;

    always #10 clk = ~clk;

    pfr_read_ctrl #(
        .ADDR_W (AW), .DATA_W (DW), .T_ACC (T_ACC), .T_CE (T_CE),
        .T_PACC (T_PACC), .T_OE (T_OE), .IDLE_TO (IDLE_TO)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
        .req_addr (req_addr), .rsp_valid (rsp_valid), .rsp_data (rsp_data),
        .fl_ce_n (fl_ce_n), .fl_oe_n (fl_oe_n), .fl_we_n (fl_we_n),
        .fl_addr (fl_addr), .fl_dq (fl_dq)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] patt(input logic [AW-1:0] a);
        return a[15:0] ^ 16'hA55A ^ {10'd0, a[21:16]};
    endfunction

    // Behavioural flash: data valid only after every applicable delay has passed
    int            m_wrd = 0, m_oe = 0;
    bit            m_loaded = 0, m_prev_ok = 0;
    logic [AW-1:0] m_prev = '0;

    always @(negedge clk) begin
        if (!rst_n || fl_ce_n) begin
            m_wrd = 0; m_oe = 0; m_loaded = 0; m_prev_ok = 0;
        end else begin
            if (!m_prev_ok || (fl_addr[AW-1:2] != m_prev[AW-1:2])) begin
                m_wrd = 1; m_loaded = 0;
            end else if (fl_addr != m_prev) begin
                m_wrd = 1;
            end else if (m_wrd < 1000) begin
                m_wrd++;
            end
            if (m_wrd >= T_FULL) m_loaded = 1;
            if (fl_oe_n) m_oe = 0; else if (m_oe < 1000) m_oe++;
            m_prev = fl_addr; m_prev_ok = 1;
        end
        if (!fl_ce_n && !fl_oe_n && m_oe >= T_OE &&
            (m_wrd >= T_FULL || (m_loaded && m_wrd >= T_PACC)))
            fl_dq = patt(fl_addr);
        else
            fl_dq = ~patt(fl_addr);
    end

    // Bench view of page state
    bit            b_open = 0;
    logic [AW-3:0] b_page = '0;

    task automatic do_read(input logic [AW-1:0] a, input int gap);
        bit    exp_hit;
        int    cyc;
        int    exp_lat;
        string tag;
        for (int i = 1; i <= gap; i++) begin
            @(negedge clk);
            if (b_open && i == 1) chk(!rsp_valid, "R8", "rsp pulse width", rsp_valid, 0);
            chk(fl_ce_n == (!b_open || i >= IDLE_TO), "R7", "ce_n during idle gap",
                fl_ce_n, (!b_open || i >= IDLE_TO));
            if (!fl_ce_n) chk(fl_oe_n, "R10", "oe_n between accesses", fl_oe_n, 1);
        end
        exp_hit = b_open && (gap <= IDLE_TO - 1) && (a[AW-1:2] == b_page);
        if (exp_hit) tag = "R5";
        else if (b_open && gap >= IDLE_TO && a[AW-1:2] == b_page) tag = "R7";
        else if (b_open && gap < IDLE_TO) tag = "R6";
        else tag = "R4";
        exp_lat = exp_hit ? E_HIT + 1 : E_MISS + 1;
        req_valid = 1'b1;
        req_addr  = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!fl_ce_n && !fl_oe_n && fl_we_n, "R2", "strobes in access",
            {fl_ce_n, fl_oe_n, fl_we_n}, 3'b001);
        chk(fl_addr == a, "R3", "address launched", fl_addr, a);
        chk(!req_ready, "R9", "ready low during access", req_ready, 0);
        cyc = 0;
        while (!rsp_valid && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc == exp_lat, tag, "response latency", cyc, exp_lat);
        chk(rsp_data == patt(a), "R8", "read data", rsp_data, patt(a));
        chk(fl_addr == a, "R3", "address held", fl_addr, a);
        chk(fl_oe_n && !fl_ce_n, "R10", "oe_n high at response", {fl_ce_n, fl_oe_n}, 2'b01);
        chk(req_ready, "R9", "ready at response", req_ready, 1);
        b_open = 1;
        b_page = a[AW-1:2];
    endtask

    initial begin
        logic [AW-1:0] cur;
        void'($urandom(32'd31337));
        repeat (3) @(negedge clk);
        chk(fl_ce_n && fl_oe_n && fl_we_n && !rsp_valid && req_ready, "R1", "reset outputs",
            {fl_ce_n, fl_oe_n, fl_we_n, rsp_valid, req_ready}, 5'b11101);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fl_ce_n && fl_oe_n && !rsp_valid && req_ready, "R1", "after reset",
            {fl_ce_n, fl_oe_n, rsp_valid, req_ready}, 4'b1101);

        // Directed corner cases
        do_read(22'h01_2340, 2);          // R4 cold miss
        do_read(22'h01_2341, 0);          // R5 hits on each word offset
        do_read(22'h01_2342, 1);
        do_read(22'h01_2343, 0);
        do_read(22'h01_2344, 0);          // R6 next page
        do_read(22'h01_2345, IDLE_TO - 1); // R5 last cycle before release
        do_read(22'h01_2346, IDLE_TO);     // R7 released, full latency
        do_read(22'h3F_FFFC, 0);          // R6 far page
        do_read(22'h3F_FFFF, 0);          // R5

        // Seeded random mix
        cur = 22'h3F_FFFF;
        for (int n = 0; n < 200; n++) begin
            int sel, g;
            sel = $urandom_range(0, 3);
            case (sel)
                0, 1: cur = {cur[AW-1:2], 2'($urandom_range(0, 3))};
                2:    cur = cur + 22'd4;
                default: cur = AW'($urandom);
            endcase
            g = ($urandom_range(0, 9) < 6) ? $urandom_range(0, 2)
                                           : $urandom_range(IDLE_TO - 2, IDLE_TO + 2);
            do_read(cur, g);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 100000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule